// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a byte-wide configuration port that a host reaches through two adjacent I/O addresses: an index address and, one above it, a data address. The index address picks a configuration register and the data address reads or writes that register. After reset the port is locked. Data reads return 0xFF, index reads return 0xFF, and writes change nothing. The only exception is the unlock key, which is the byte 0x87 written twice in a row to the index address. Writing 0xAA to the index address locks the port again.

Once the port is unlocked, the global registers below index 0x30 hold a logical-device select, a device ID, a revision and a strap register that shows which base address is in use. Indices from 0x30 upward belong to the logical device currently selected. The block keeps one activation bit per logical device at index 0x30. It forwards every index above 0x30 to the surrounding logic as single-cycle read and write strobes, together with the device number, the index and the write data. An external strap input chooses the base address: 0x2E when low, 0x4E when high.

Top module: `cfgport`

## Requirements
- R1: After reset the port is locked, the index and the logical-device select are 0x00, every activation bit is 0, and a data-port read returns 0xFF.
- R2: While the port is locked, reads of the index and data addresses return 0xFF. Data writes, and index writes of any byte other than 0x87, change no register, and no per-device strobe is raised.
- R3: Two index writes of 0x87 in a row unlock the port. An index write of any other value between them restarts the key match. Data-port accesses do not disturb the match.
- R4: While the port is unlocked, an index write of 0xAA locks it and leaves the index register unchanged.
- R5: With the strap low, the index address is 0x2E and the data address is 0x2F. With the strap high, they are 0x4E and 0x4F. Accesses at any other address have no effect, and reads there return 0x00.
- R6: Index 0x20 reads the DEV_ID parameter and index 0x21 reads DEV_REV. Index 0x26 reads the strap in bit 6, with all other bits 0. Writes to these three indices are ignored.
- R7: Index 0x07 is a read/write logical-device select.
- R8: Index 0x30 holds the activation bit, bit 0, of the selected logical device. It reads back as {7'b0, bit} and drives ld_active[n]. A select of NUM_LD or more reads 0x00 there and ignores writes.
- R9: While the port is unlocked, a data write to an index above 0x30 raises ld_wr for that cycle, with ld_num, ld_idx and ld_wdata valid. A data read raises ld_rd and returns ld_rdata.
- R10: While the port is unlocked, an index-address read returns the current index. A data read of an unimplemented index below 0x30 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_sel | input | 1 | Base strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write, one access per asserted cycle |
| io_rd | input | 1 | Host read |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational during io_rd |
| ld_num | output | 8 | Selected logical-device number |
| ld_idx | output | 8 | Current index |
| ld_wdata | output | 8 | Write data for a per-device register |
| ld_wr | output | 1 | Per-device register write strobe |
| ld_rd | output | 1 | Per-device register read strobe |
| ld_rdata | input | 8 | Per-device register read data |
| ld_active | output | NUM_LD | Activation bit of each logical device |

## Verification
A key matcher stuck in the wrong state shows up at once. The next data read returns 0xFF where a register value is expected, or a real value where 0xFF is expected, and the per-device strobes appear or vanish in that same cycle. A corrupted index or device select is visible on ld_idx and ld_num in the cycle after the write that caused it. A misrouted activation bit shows on ld_active one cycle after the write. The reference model predicts every output in every cycle, so any divergence is caught within one clock of its cause.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   localparam logic [7:0] KEY_BYTE    = 8'h87;
   localparam logic [7:0] EXIT_BYTE   = 8'hAA;
   localparam logic [7:0] REG_LDN     = 8'h07;
   localparam logic [7:0] REG_ID      = 8'h20;
   localparam logic [7:0] REG_REV     = 8'h21;
   localparam logic [7:0] REG_STRAP   = 8'h26;
   localparam logic [7:0] REG_ACT     = 8'h30;
   localparam logic [7:0] LOCKED_READ = 8'hFF;

   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_HALF = 2'd1,
      KS_OPEN = 2'd2
   } key_state_e;
endpackage

// File: rtl/cfgport_key.sv
module cfgport_key
   import cfgport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       unlocked
);
   key_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         KS_IDLE: if (idx_wr && wdata == KEY_BYTE) state_d = KS_HALF;
         KS_HALF: if (idx_wr) state_d = (wdata == KEY_BYTE) ? KS_OPEN : KS_IDLE;
         KS_OPEN: if (idx_wr && wdata == EXIT_BYTE) state_d = KS_IDLE;
         default: state_d = KS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= KS_IDLE;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == KS_OPEN);

   // R3
   unlock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(idx_wr && wdata == KEY_BYTE));

   // R4
   exit_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && idx_wr && wdata == EXIT_BYTE) |=> !unlocked);
endmodule

// File: rtl/cfgport_actbank.sv
module cfgport_actbank #(
   parameter int NUM_LD = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        sel,
   input  logic              wbit,
   output logic [NUM_LD-1:0] active,
   output logic              rd_bit
);
   for (genvar i = 0; i < NUM_LD; i++) begin : g_ld
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         bit_q <= 1'b0;
         else if (wr_en && sel == 8'(i))     bit_q <= wbit;
      end
      assign active[i] = bit_q;
   end

   always_comb begin
      rd_bit = 1'b0;
      for (int i = 0; i < NUM_LD; i++)
         if (sel == 8'(i)) rd_bit = active[i];
   end

   // R8
   act_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active) |-> $past(wr_en));
endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
   import cfgport_pkg::*;
#(
   parameter logic [7:0] DEV_ID  = 8'hA0,
   parameter logic [7:0] DEV_REV = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       unlocked,
   input  logic       idx_wr,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   input  logic       base_sel,
   input  logic       act_rd_bit,
   output logic [7:0] index_q,
   output logic [7:0] ldn_q,
   output logic       act_wr,
   output logic       ext_sel,
   output logic [7:0] rd_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= 8'h00;
         ldn_q   <= 8'h00;
      end else begin
         if (unlocked && idx_wr && wdata != EXIT_BYTE) index_q <= wdata;
         if (unlocked && data_wr && index_q == REG_LDN) ldn_q <= wdata;
      end
   end

   assign act_wr  = unlocked && data_wr && (index_q == REG_ACT);
   assign ext_sel = (index_q > REG_ACT);

   always_comb begin
      case (index_q)
         REG_LDN:   rd_val = ldn_q;
         REG_ID:    rd_val = DEV_ID;
         REG_REV:   rd_val = DEV_REV;
         REG_STRAP: rd_val = {1'b0, base_sel, 6'b0};
         REG_ACT:   rd_val = {7'b0, act_rd_bit};
         default:   rd_val = 8'h00;
      endcase
   end

   // R2
   idx_hold_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(index_q));

   // R7
   ldn_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ldn_q) |-> $past(unlocked && data_wr && index_q == REG_LDN));
endmodule

// File: rtl/cfgport.sv
module cfgport
   import cfgport_pkg::*;
#(
   parameter int              ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] BASE_LO = 'h2E,
   parameter logic [ADDR_W-1:0] BASE_HI = 'h4E,
   parameter logic [7:0]      DEV_ID  = 8'hA0,
   parameter logic [7:0]      DEV_REV = 8'h01,
   parameter int              NUM_LD  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_sel,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic [7:0]        ld_num,
   output logic [7:0]        ld_idx,
   output logic [7:0]        ld_wdata,
   output logic              ld_wr,
   output logic              ld_rd,
   input  logic [7:0]        ld_rdata,
   output logic [NUM_LD-1:0] ld_active
);
   if (NUM_LD < 1 || NUM_LD > 256) begin : g_bad_num_ld
      $error("cfgport: NUM_LD must lie in 1..256");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("cfgport: ADDR_W must be at least 8");
   end
   if (BASE_LO[0] || BASE_HI[0]) begin : g_bad_base
      $error("cfgport: base addresses must be even");
   end

   logic [ADDR_W-1:0] idx_addr, data_addr;
   logic              hit_idx, hit_data, idx_wr, data_wr, data_rd;
   logic              unlocked, act_wr, act_rd_bit, ext_sel;
   logic [7:0]        index_q, ldn_q, rd_val;

   assign idx_addr  = base_sel ? BASE_HI : BASE_LO;
   assign data_addr = idx_addr + ADDR_W'(1);
   assign hit_idx   = (io_addr == idx_addr);
   assign hit_data  = (io_addr == data_addr);
   assign idx_wr    = io_wr && hit_idx;
   assign data_wr   = io_wr && hit_data;
   assign data_rd   = io_rd && hit_data;

   cfgport_key u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (idx_wr),
      .wdata    (io_wdata),
      .unlocked (unlocked)
   );

   cfgport_regfile #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .unlocked   (unlocked),
      .idx_wr     (idx_wr),
      .data_wr    (data_wr),
      .wdata      (io_wdata),
      .base_sel   (base_sel),
      .act_rd_bit (act_rd_bit),
      .index_q    (index_q),
      .ldn_q      (ldn_q),
      .act_wr     (act_wr),
      .ext_sel    (ext_sel),
      .rd_val     (rd_val)
   );

   cfgport_actbank #(.NUM_LD(NUM_LD)) u_act (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (act_wr),
      .sel    (ldn_q),
      .wbit   (io_wdata[0]),
      .active (ld_active),
      .rd_bit (act_rd_bit)
   );

   assign ld_num   = ldn_q;
   assign ld_idx   = index_q;
   assign ld_wdata = io_wdata;
   assign ld_wr    = unlocked && data_wr && ext_sel;
   assign ld_rd    = unlocked && data_rd && ext_sel;

   always_comb begin
      io_rdata = 8'h00;
      if (io_rd && hit_idx)
         io_rdata = unlocked ? index_q : LOCKED_READ;
      else if (data_rd)
         io_rdata = !unlocked ? LOCKED_READ : (ext_sel ? ld_rdata : rd_val);
   end

   // R9
   strobe_index_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_wr || ld_rd) |=> $stable(ld_idx));

   // R2
   no_strobe_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && idx_wr && io_wdata == EXIT_BYTE) |=> !(ld_wr || ld_rd));
endmodule

// File: tb/cfgport_test.sv
module cfgport_test;
   localparam int NLD = 10;
   localparam logic [7:0] ID = 8'hA0, REV = 8'h01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_sel = 1'b0;
   logic [15:0] io_addr = 16'h0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h0;
   logic [7:0]  io_rdata, ld_num, ld_idx, ld_wdata, ld_rdata;
   logic        ld_wr, ld_rd;
   logic [NLD-1:0] ld_active;

   int checks = 0, failures = 0;

   // bench-side per-device register stub
   assign ld_rdata = ld_idx ^ {ld_num[3:0], 4'h5};

   cfgport uut (
      .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
      .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .ld_num(ld_num), .ld_idx(ld_idx), .ld_wdata(ld_wdata), .ld_wr(ld_wr),
      .ld_rd(ld_rd), .ld_rdata(ld_rdata), .ld_active(ld_active)
   );

   always #10 clk = ~clk;

   // behavioural reference model
   bit       m_unl = 0, m_seen = 0;
   int       m_idx = 0, m_ldn = 0;
   bit       m_act[NLD];

   function automatic int ia(); return base_sel ? 'h4E : 'h2E; endfunction

   function automatic logic [7:0] exp_rdata();
      if (!io_rd) return 8'h00;
      if (io_addr == ia()) return m_unl ? 8'(m_idx) : 8'hFF;
      if (io_addr != ia() + 1) return 8'h00;
      if (!m_unl) return 8'hFF;
      if (m_idx > 'h30) return 8'(m_idx) ^ {4'(m_ldn), 4'h5};
      case (m_idx)
         'h07: return 8'(m_ldn);
         'h20: return ID;
         'h21: return REV;
         'h26: return base_sel ? 8'h40 : 8'h00;
         'h30: return (m_ldn < NLD) ? {7'b0, m_act[m_ldn]} : 8'h00;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic [NLD-1:0] ea;
      bit dh, ew, er;
      for (int i = 0; i < NLD; i++) ea[i] = m_act[i];
      dh = (io_addr == ia() + 1) && m_unl && (m_idx > 'h30);
      ew = io_wr && dh;
      er = io_rd && dh;
      check(io_rdata == exp_rdata(), tag, "io_rdata", io_rdata, exp_rdata());
      check(ld_wr == ew && ld_rd == er, tag, "strobes", {ld_wr, ld_rd}, {ew, er});
      check(ld_active == ea, tag, "ld_active", ld_active, ea);
      check(ld_idx == 8'(m_idx) && ld_num == 8'(m_ldn), tag, "idx/num",
            {ld_idx, ld_num}, {8'(m_idx), 8'(m_ldn)});
      if (ew) check(ld_wdata == io_wdata, tag, "ld_wdata", ld_wdata, io_wdata);
   endtask

   task automatic update(input bit w, input logic [15:0] a, input logic [7:0] d);
      if (!w) return;
      if (a == ia()) begin
         if (!m_unl) begin
            if (d == 8'h87) begin
               if (m_seen) begin m_unl = 1; m_seen = 0; end
               else m_seen = 1;
            end else m_seen = 0;
         end else if (d == 8'hAA) begin
            m_unl = 0; m_seen = 0;
         end else m_idx = d;
      end else if (a == ia() + 1 && m_unl) begin
         if (m_idx == 'h07) m_ldn = d;
         else if (m_idx == 'h30 && m_ldn < NLD) m_act[m_ldn] = d[0];
      end
   endtask

   task automatic cyc(input bit w, input bit r, input logic [15:0] a,
                      input logic [7:0] d, input string tag);
      @(negedge clk);
      io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
      #2 compare(tag);
      @(posedge clk); #1;
      update(w, a, d);
      io_wr = 0; io_rd = 0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
      cyc(1, 0, a, d, tag);
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] lit, input string tag);
      @(negedge clk);
      io_wr = 0; io_rd = 1; io_addr = a; io_wdata = 8'h00;
      #2 compare(tag);
      check(io_rdata == lit, tag, "literal read", io_rdata, lit);
      @(posedge clk); #1;
      io_rd = 0;
   endtask

   initial begin
      #4_000_000;
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      rd('h2F, 8'hFF, "R1");
      check(ld_active == '0 && ld_idx == 8'h00 && ld_num == 8'h00, "R1", "reset regs",
            {ld_active, ld_idx, ld_num}, 0);
      // R2 locked behaviour
      wr('h2F, 8'h33, "R2");
      wr('h2E, 8'h07, "R2");
      rd('h2E, 8'hFF, "R2");
      rd('h2F, 8'hFF, "R2");
      check(ld_idx == 8'h00, "R2", "index untouched", ld_idx, 0);
      // R3 broken key, then key with data access between
      wr('h2E, 8'h87, "R3");
      wr('h2E, 8'h12, "R3");
      wr('h2E, 8'h87, "R3");
      rd('h2F, 8'hFF, "R3");
      wr('h2F, 8'h01, "R3");
      wr('h2E, 8'h87, "R3");
      rd('h2E, 8'h00, "R3");
      // R10 index readback and unimplemented index
      wr('h2E, 8'h10, "R10");
      rd('h2E, 8'h10, "R10");
      rd('h2F, 8'h00, "R10");
      // R6 identity registers
      wr('h2E, 8'h20, "R6");
      rd('h2F, ID, "R6");
      wr('h2F, 8'h55, "R6");
      rd('h2F, ID, "R6");
      wr('h2E, 8'h21, "R6");
      rd('h2F, REV, "R6");
      wr('h2E, 8'h26, "R6");
      rd('h2F, 8'h00, "R6");
      // R7 device select
      wr('h2E, 8'h07, "R7");
      wr('h2F, 8'h08, "R7");
      rd('h2F, 8'h08, "R7");
      // R8 activation
      wr('h2E, 8'h30, "R8");
      wr('h2F, 8'h03, "R8");
      rd('h2F, 8'h01, "R8");
      check(ld_active == 10'h100, "R8", "active bit 8", ld_active, 10'h100);
      wr('h2E, 8'h07, "R8");
      wr('h2F, 8'h0C, "R8");
      wr('h2E, 8'h30, "R8");
      wr('h2F, 8'h01, "R8");
      rd('h2F, 8'h00, "R8");
      check(ld_active == 10'h100, "R8", "out of range ignored", ld_active, 10'h100);
      wr('h2E, 8'h07, "R8");
      wr('h2F, 8'h08, "R8");
      wr('h2E, 8'h30, "R8");
      wr('h2F, 8'h00, "R8");
      // R9 forwarded registers
      wr('h2E, 8'h31, "R9");
      wr('h2F, 8'h9C, "R9");
      rd('h2F, 8'h31 ^ 8'h85, "R9");
      wr('h2E, 8'hF5, "R9");
      wr('h2F, 8'h02, "R9");
      rd('h2F, 8'hF5 ^ 8'h85, "R9");
      // R4 exit
      wr('h2E, 8'hAA, "R4");
      check(ld_idx == 8'hF5, "R4", "index kept", ld_idx, 8'hF5);
      rd('h2F, 8'hFF, "R4");
      wr('h2F, 8'h00, "R4");
      // R5 alternate base
      base_sel = 1;
      wr('h2E, 8'h87, "R5");
      wr('h2E, 8'h87, "R5");
      rd('h4F, 8'hFF, "R5");
      wr('h4E, 8'h87, "R5");
      wr('h4E, 8'h87, "R5");
      rd('h4E, 8'hF5, "R5");
      rd('h2F, 8'h00, "R5");
      wr('h4E, 8'h26, "R5");
      rd('h4F, 8'h40, "R6");
      wr('h2E, 8'h07, "R5");
      rd('h4E, 8'h26, "R5");
      wr('h4E, 8'hAA, "R4");
      rd('h4F, 8'hFF, "R4");
      repeat (2) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule